// File: doc/BRIEF.md
# Processor Power-On Reset Sequencer

This block sits in a companion FPGA next to a multicore processor and takes that processor out of power-on reset. It waits for a power-good indication and then for a clock-stable indication. It holds every reset line low for a minimum settling interval. After that it releases three active-low reset lines in a fixed order: first the warm reset line, then the power-on reset line, and last the full reset line. Every interval is counted in cycles of the free-running FPGA clock. The counts are worked out at elaboration from the FPGA clock period and the slowest allowed reference-clock period.

A configuration word is driven onto the processor's boot-strap pins for a window around the full-reset release edge, because the processor samples the strap levels on that edge. The pins are then tri-stated. The sequencer waits for the processor's reset-status output to rise. If status does not arrive within a timeout, the block flags an error and repeats the sequence from the hold step. A start input re-runs the sequence on demand. Any loss of power-good drops every line straight back to its inactive level.

Top module: `por_sequencer`

## Requirements
- R1: While the synchronous reset is low or `pwr_good` is low, `warm_rst_n`, `por_n` and `full_rst_n` are 0, `strap_oe` is 0, `strap_o` is all zeros, and `done` and `err` are 0.
- R2: After `pwr_good` is high, nothing is released until `clk_stable` is seen high. From then on every reset line stays low for at least the longer of `PWR_HOLD_NS` and 500 reference-clock periods.
- R3: `warm_rst_n` rises first. `por_n` rises `WARM_GAP_CYC` cycles later, and `por_n` is never high while `warm_rst_n` is low.
- R4: `full_rst_n` rises no earlier than 24 reference-clock periods after `por_n` rises, and only while `por_n` is high.
- R5: `strap_oe` rises together with `por_n`. `strap_o` does not change while `strap_oe` is high. The pins are driven for at least 12 reference-clock periods before and at least 12 after the `full_rst_n` rising edge. The word is the value of `cfg_i` frozen in the last cycle before `por_n` rises. Its layout is: bit 0 byte order, bits 13:1 boot mode, bits 15:14 PCIe mode, bit 16 PCIe enable, bit 17 network-coprocessor clock select.
- R6: Outside the strap window `strap_oe` is 0 and `strap_o` is 0. `strap_oe` is high only while `por_n` is high.
- R7: Once the strap pins are tri-stated, `rst_stat` high leads to `done` high on the next cycle, even if status was already high before that. `done` stays high, with all three lines high, until `start` or loss of power.
- R8: If `rst_stat` stays low for `STAT_TIMEOUT_REF` reference-clock periods after the strap pins are released, `err` pulses high for exactly one cycle, all lines drop low, and the sequence restarts at the hold step.
- R9: A one-cycle `start` while power and clock are good and the hold step has been reached drives all three lines low on the next cycle and re-runs the full sequence.
- R10: `pwr_good` low drives all three lines low and `strap_oe` low on the next cycle, from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running FPGA clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good | input | 1 | Processor I/O supply good, synchronous to clk |
| clk_stable | input | 1 | Processor reference clock running, synchronous to clk |
| start | input | 1 | One-cycle request to re-run the sequence |
| rst_stat | input | 1 | Processor reset-status output, synchronised to clk |
| cfg_i | input | 18 | Configuration word for the strap pins |
| warm_rst_n | output | 1 | Warm reset line, active low |
| por_n | output | 1 | Power-on reset line, active low |
| full_rst_n | output | 1 | Full reset line, active low |
| strap_o | output | 18 | Strap pin values |
| strap_oe | output | 1 | Strap pad output enable (0 = high impedance) |
| done | output | 1 | Sequence complete, processor out of reset |
| err | output | 1 | One-cycle pulse on status timeout |

## Verification
The embedded assertions check the properties that hold on every cycle. These are the nesting of the three lines (warm before power-on before full), strap stability while driven, the full-reset edge falling inside the drive window, the one-cycle error pulse, and the collapse of all lines one cycle after power-good drops. The minimum interval lengths in microseconds and reference periods, the freezing of the configuration word against late input changes, the timeout-and-retry path, restart by `start`, and status that arrives before the strap pins are released can only be shown by the bench. It measures the time between observed edges and follows a cycle-level reference model through those scenarios.

// File: rtl/por_seq_pkg.sv
// Package: shared widths, state encoding and the boot configuration layout
// for the power-on reset sequencer. Assumes one-hot state encoding
// throughout; the bit index constants are used to decode outputs.
package por_seq_pkg;

    // Width of the boot-mode field on the strap pins.
    localparam int BOOT_W      = 13;
    // Width of the PCIe mode field on the strap pins.
    localparam int PCIE_MODE_W = 2;
    // Total strap word width: byte order, boot mode, PCIe mode, PCIe enable,
    // network-coprocessor clock select.
    localparam int CFG_W       = BOOT_W + PCIE_MODE_W + 3;

    // Strap word layout, LSB last in the declaration.
    typedef struct packed {
        logic                   netcp_clk_sel;
        logic                   pcie_en;
        logic [PCIE_MODE_W-1:0] pcie_mode;
        logic [BOOT_W-1:0]      boot_mode;
        logic                   byte_order;
    } boot_cfg_t;

    // Number of sequencer states.
    localparam int N_ST = 10;

    // Bit positions of the one-hot state vector.
    localparam int I_IDLE      = 0;
    localparam int I_WAIT_PWR  = 1;
    localparam int I_HOLD_POR  = 2;
    localparam int I_REL_WARM  = 3;
    localparam int I_REL_POR   = 4;
    localparam int I_HOLD_FULL = 5;
    localparam int I_STRAP     = 6;
    localparam int I_WAIT_STAT = 7;
    localparam int I_DONE      = 8;
    localparam int I_ERROR     = 9;

    // One-hot state type.
    typedef enum logic [N_ST-1:0] {
        S_IDLE      = 10'b00_0000_0001,
        S_WAIT_PWR  = 10'b00_0000_0010,
        S_HOLD_POR  = 10'b00_0000_0100,
        S_REL_WARM  = 10'b00_0000_1000,
        S_REL_POR   = 10'b00_0001_0000,
        S_HOLD_FULL = 10'b00_0010_0000,
        S_STRAP     = 10'b00_0100_0000,
        S_WAIT_STAT = 10'b00_1000_0000,
        S_DONE      = 10'b01_0000_0000,
        S_ERROR     = 10'b10_0000_0000
    } seq_state_e;

endpackage

// File: rtl/por_seq_timer.sv
// Interval timer: a single down-counter shared by all timed states.
// Assumes the controller loads (duration - 1) on the cycle it enters a
// timed state; expired is high once the count reaches zero, so the state
// lasts exactly `duration` cycles.
module por_seq_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt_q;

    // Load on state entry, otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    // Expiry flag for the controller.
    assign expired = (cnt_q == '0);

endmodule

// File: rtl/por_seq_fsm.sv
// Sequencer controller: one-hot state machine that steps through the
// power-up hold, the ordered release of the three reset lines, the strap
// window and the status handshake. Assumes all inputs are already
// synchronous to clk. Loss of power-good has priority over everything,
// then a start request, then the normal progression.
module por_seq_fsm
    import por_seq_pkg::*;
#(
    parameter int CW        = 16,
    parameter int N_HOLD    = 4,
    parameter int N_GAP     = 4,
    parameter int N_FULL    = 4,
    parameter int N_STRAP   = 4,
    parameter int N_TMO     = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_good,
    input  logic          clk_stable,
    input  logic          start,
    input  logic          rst_stat,
    input  logic          expired,
    output seq_state_e    state,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val
);

    localparam logic [CW-1:0] V_HOLD  = CW'(N_HOLD - 1);
    localparam logic [CW-1:0] V_GAP   = CW'(N_GAP - 1);
    localparam logic [CW-1:0] V_FULL  = CW'(N_FULL - 1);
    localparam logic [CW-1:0] V_STRAP = CW'(N_STRAP - 1);
    localparam logic [CW-1:0] V_TMO   = CW'(N_TMO - 1);

    seq_state_e state_q;
    seq_state_e state_d;
    logic       restartable;

    // States from which a start request restarts the hold step.
    assign restartable = !(state_q[I_IDLE] || state_q[I_WAIT_PWR]);

    // Next-state and timer-load decision.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (!pwr_good) begin
            state_d = S_IDLE;
        end else if (start && restartable) begin
            state_d  = S_HOLD_POR;
            tmr_load = 1'b1;
            tmr_val  = V_HOLD;
        end else begin
            case (state_q)
                S_IDLE: begin
                    state_d = S_WAIT_PWR;
                end
                S_WAIT_PWR: begin
                    if (clk_stable) begin
                        state_d  = S_HOLD_POR;
                        tmr_load = 1'b1;
                        tmr_val  = V_HOLD;
                    end
                end
                S_HOLD_POR: begin
                    if (expired) begin
                        state_d  = S_REL_WARM;
                        tmr_load = 1'b1;
                        tmr_val  = V_GAP;
                    end
                end
                S_REL_WARM: begin
                    if (expired) begin
                        state_d = S_REL_POR;
                    end
                end
                S_REL_POR: begin
                    state_d  = S_HOLD_FULL;
                    tmr_load = 1'b1;
                    tmr_val  = V_FULL;
                end
                S_HOLD_FULL: begin
                    if (expired) begin
                        state_d  = S_STRAP;
                        tmr_load = 1'b1;
                        tmr_val  = V_STRAP;
                    end
                end
                S_STRAP: begin
                    if (expired) begin
                        state_d  = S_WAIT_STAT;
                        tmr_load = 1'b1;
                        tmr_val  = V_TMO;
                    end
                end
                S_WAIT_STAT: begin
                    if (rst_stat) begin
                        state_d = S_DONE;
                    end else if (expired) begin
                        state_d = S_ERROR;
                    end
                end
                S_DONE: begin
                    state_d = S_DONE;
                end
                S_ERROR: begin
                    state_d  = S_HOLD_POR;
                    tmr_load = 1'b1;
                    tmr_val  = V_HOLD;
                end
                default: begin
                    state_d = S_IDLE;
                end
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign state = state_q;

    // R8: the error state never lasts longer than one cycle.
    p_err_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        state_q[I_ERROR] |=> !state_q[I_ERROR]);

    // R2: the release steps are only reachable through the hold step.
    p_hold_before_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q[I_REL_WARM]) |-> $past(state_q[I_HOLD_POR]));

endmodule

// File: rtl/por_seq_strap.sv
// Strap driver: freezes the configuration word before the drive window
// opens and presents it on the strap pins while the window is open.
// Assumes `capture` is high in the states before the window and low from
// the window onwards, so the driven value cannot change inside it.
module por_seq_strap
    import por_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic             drive,
    input  logic [CFG_W-1:0] cfg_i,
    output logic [CFG_W-1:0] strap_o,
    output logic             strap_oe
);

    boot_cfg_t cfg_q;

    // Track the configuration input until the window opens, then hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (capture) begin
            cfg_q <= boot_cfg_t'(cfg_i);
        end
    end

    // Present the frozen word only while the window is open.
    assign strap_o  = drive ? CFG_W'(cfg_q) : '0;
    assign strap_oe = drive;

    // R5: the driven word is steady for the whole window.
    p_strap_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (strap_oe && $past(strap_oe)) |-> $stable(strap_o));

endmodule

// File: rtl/por_sequencer.sv
// Top level of the processor power-on reset sequencer. Derives every
// interval in FPGA clock cycles from the FPGA clock period and the slowest
// reference-clock period (rounding up), instantiates the controller, the
// shared interval timer and the strap driver, and decodes the reset lines
// from the one-hot state. Assumes pwr_good, clk_stable, start and rst_stat
// are already synchronous to clk.
module por_sequencer
    import por_seq_pkg::*;
#(
    parameter int CLK_PERIOD_PS    = 5000,
    parameter int REF_PERIOD_PS    = 33330,
    parameter int PWR_HOLD_NS      = 100000,
    parameter int POR_REF_CYC      = 500,
    parameter int FULL_REF_CYC     = 24,
    parameter int STRAP_REF_CYC    = 12,
    parameter int STAT_TIMEOUT_REF = 60000,
    parameter int WARM_GAP_CYC     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_good,
    input  logic             clk_stable,
    input  logic             start,
    input  logic             rst_stat,
    input  logic [CFG_W-1:0] cfg_i,
    output logic             warm_rst_n,
    output logic             por_n,
    output logic             full_rst_n,
    output logic [CFG_W-1:0] strap_o,
    output logic             strap_oe,
    output logic             done,
    output logic             err
);

    // Interval lengths in FPGA cycles, rounded up.
    localparam longint CP      = longint'(CLK_PERIOD_PS);
    localparam longint HOLD_US = (longint'(PWR_HOLD_NS) * 1000 + CP - 1) / CP;
    localparam longint HOLD_RF = (longint'(POR_REF_CYC) * REF_PERIOD_PS + CP - 1) / CP;
    localparam longint FULL_RF = (longint'(FULL_REF_CYC) * REF_PERIOD_PS + CP - 1) / CP;
    localparam longint STRP_RF = (longint'(STRAP_REF_CYC) * REF_PERIOD_PS + CP - 1) / CP;
    localparam longint TMO_RF  = (longint'(STAT_TIMEOUT_REF) * REF_PERIOD_PS + CP - 1) / CP;

    localparam int N_HOLD  = int'((HOLD_US > HOLD_RF) ? HOLD_US : HOLD_RF);
    localparam int N_FULL  = int'((FULL_RF > STRP_RF) ? FULL_RF : STRP_RF);
    localparam int N_STRAP = int'(STRP_RF);
    localparam int N_TMO   = int'(TMO_RF);
    localparam int N_GAP   = (WARM_GAP_CYC < 1) ? 1 : WARM_GAP_CYC;

    localparam int N_M1    = (N_HOLD > N_FULL) ? N_HOLD : N_FULL;
    localparam int N_M2    = (N_STRAP > N_TMO) ? N_STRAP : N_TMO;
    localparam int N_MAX   = (N_M1 > N_M2) ? N_M1 : N_M2;
    localparam int CW      = $clog2(N_MAX + 1);

    seq_state_e    state;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_exp;
    logic          strap_cap;
    logic          strap_drv;

    // Controller.
    por_seq_fsm #(
        .CW      (CW),
        .N_HOLD  (N_HOLD),
        .N_GAP   (N_GAP),
        .N_FULL  (N_FULL),
        .N_STRAP (N_STRAP),
        .N_TMO   (N_TMO)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_good   (pwr_good),
        .clk_stable (clk_stable),
        .start      (start),
        .rst_stat   (rst_stat),
        .expired    (tmr_exp),
        .state      (state),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val)
    );

    // Shared interval timer.
    por_seq_timer #(
        .CW (CW)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    // Strap capture runs up to the cycle before the power-on release.
    assign strap_cap = state[I_WAIT_PWR] | state[I_HOLD_POR] | state[I_REL_WARM];
    // Strap drive window: power-on release through the post-edge hold.
    assign strap_drv = state[I_REL_POR] | state[I_HOLD_FULL] | state[I_STRAP];

    // Strap driver.
    por_seq_strap u_strap (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (strap_cap),
        .drive    (strap_drv),
        .cfg_i    (cfg_i),
        .strap_o  (strap_o),
        .strap_oe (strap_oe)
    );

    // Reset line decode: each line is high from its release state onwards.
    assign warm_rst_n = state[I_REL_WARM] | state[I_REL_POR] | state[I_HOLD_FULL]
                      | state[I_STRAP] | state[I_WAIT_STAT] | state[I_DONE];
    assign por_n      = state[I_REL_POR] | state[I_HOLD_FULL] | state[I_STRAP]
                      | state[I_WAIT_STAT] | state[I_DONE];
    assign full_rst_n = state[I_STRAP] | state[I_WAIT_STAT] | state[I_DONE];
    assign done       = state[I_DONE];
    assign err        = state[I_ERROR];

    // R3: power-on line only rises after the warm line is already high.
    p_warm_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(por_n) |-> $past(warm_rst_n));

    // R3: power-on line is never high with the warm line low.
    p_nesting_r3: assert property (@(posedge clk) disable iff (!rst_n)
        por_n |-> warm_rst_n);

    // R4: full reset line only rises after power-on has been high.
    p_full_after_por_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_rst_n) |-> $past(por_n));

    // R5: the full-reset edge falls inside the strap drive window.
    p_edge_in_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_rst_n) |-> (strap_oe && $past(strap_oe)));

    // R6: straps are only driven while the power-on line is high.
    p_strap_needs_por_r6: assert property (@(posedge clk) disable iff (!rst_n)
        strap_oe |-> por_n);

    // R7: completion implies all lines released and straps tri-stated.
    p_done_lines_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (full_rst_n && !strap_oe));

    // R8: after the error pulse every line is low again.
    p_err_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> (!err && !warm_rst_n));

    // R10: loss of power-good collapses every output next cycle.
    p_pwr_loss_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> (!warm_rst_n && !por_n && !full_rst_n && !strap_oe));

endmodule

// File: tb/tb_por_sequencer.sv
`timescale 1ns/1ps
// Bench for the power-on reset sequencer: a behavioural reference model
// compared on every clock, edge-interval measurements, and directed
// scenarios for restart, timeout, early status and power loss.
module tb_por_sequencer;

    localparam int CLK_PS   = 5000;
    localparam int REF_PS   = 33330;
    localparam int PWR_NS   = 2000;
    localparam int TMO_REF  = 100;
    localparam int GAP      = 8;
    localparam int W        = 18;

    // Expected durations in FPGA cycles, rounded up from the requirements.
    localparam int E_HOLD   = ((PWR_NS * 1000 + CLK_PS - 1) / CLK_PS) >
                              ((500 * REF_PS + CLK_PS - 1) / CLK_PS) ?
                              ((PWR_NS * 1000 + CLK_PS - 1) / CLK_PS) :
                              ((500 * REF_PS + CLK_PS - 1) / CLK_PS);
    localparam int E_FULL   = (24 * REF_PS + CLK_PS - 1) / CLK_PS;
    localparam int E_STRAP  = (12 * REF_PS + CLK_PS - 1) / CLK_PS;
    localparam int E_TMO    = (TMO_REF * REF_PS + CLK_PS - 1) / CLK_PS;

    localparam logic [W-1:0] CFG_A = 18'h2_A5C3;
    localparam logic [W-1:0] CFG_B = 18'h1_3C5A;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic         rst_n, pwr_good, clk_stable, start, rst_stat;
    logic [W-1:0] cfg_i;
    logic         warm_rst_n, por_n, full_rst_n, strap_oe, done, err;
    logic [W-1:0] strap_o;

    por_sequencer #(
        .CLK_PERIOD_PS    (CLK_PS),
        .REF_PERIOD_PS    (REF_PS),
        .PWR_HOLD_NS      (PWR_NS),
        .STAT_TIMEOUT_REF (TMO_REF),
        .WARM_GAP_CYC     (GAP)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_good   (pwr_good),
        .clk_stable (clk_stable),
        .start      (start),
        .rst_stat   (rst_stat),
        .cfg_i      (cfg_i),
        .warm_rst_n (warm_rst_n),
        .por_n      (por_n),
        .full_rst_n (full_rst_n),
        .strap_o    (strap_o),
        .strap_oe   (strap_oe),
        .done       (done),
        .err        (err)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Record one check and report a failure.
    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    // phases: 0 idle, 1 wait clock, 2 hold, 3 warm released, 4 por edge,
    // 5 full hold, 6 strap after edge, 7 wait status, 8 done, 9 error
    int           ph = 0;
    int           left = 0;
    logic [W-1:0] cap = '0;
    int           cyc = 0;
    int           anchor = 0;
    bit           started = 0;

    always @(posedge clk) begin
        cyc++;
        started = 1;
        if (!rst_n || !pwr_good || !clk_stable || (start && ph >= 2) || ph == 9)
            anchor = cyc;
        if (!rst_n || !pwr_good) begin
            ph = 0;
        end else if (start && ph >= 2) begin
            ph = 2; left = E_HOLD;
        end else begin
            case (ph)
                0: ph = 1;
                1: if (clk_stable) begin ph = 2; left = E_HOLD; end
                2: if (left == 1) begin ph = 3; left = GAP; end else left--;
                3: if (left == 1) begin ph = 4; cap = cfg_i; end else left--;
                4: begin ph = 5; left = E_FULL; end
                5: if (left == 1) begin ph = 6; left = E_STRAP; end else left--;
                6: if (left == 1) begin ph = 7; left = E_TMO; end else left--;
                7: if (rst_stat) ph = 8;
                   else if (left == 1) ph = 9;
                   else left--;
                8: ph = 8;
                default: begin ph = 2; left = E_HOLD; end
            endcase
        end
    end

    function automatic string req_of(input int p);
        case (p)
            0: return "R1";
            1: return "R2";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R4";
            6: return "R5";
            7: return "R6";
            8: return "R7";
            default: return "R8";
        endcase
    endfunction

    // ---------------- per-cycle compare and edge timing ----------------
    int  t_warm = 0, t_por = 0, t_full = 0, t_oe_r = 0;
    logic p_warm = 0, p_por = 0, p_full = 0, p_oe = 0;

    always @(negedge clk) begin
        if (started && !finished) begin
            logic [W+5:0] act, exp;
            bit m_warm, m_por, m_full, m_oe;
            m_warm = (ph >= 3 && ph <= 8);
            m_por  = (ph >= 4 && ph <= 8);
            m_full = (ph >= 6 && ph <= 8);
            m_oe   = (ph >= 4 && ph <= 6);
            exp = {m_warm, m_por, m_full, m_oe, ph == 8, ph == 9, m_oe ? cap : {W{1'b0}}};
            act = {warm_rst_n, por_n, full_rst_n, strap_oe, done, err, strap_o};
            chk(act === exp, req_of(ph), "model compare", longint'(act), longint'(exp));

            // Edge timing measured from the observed outputs.
            if (warm_rst_n && !p_warm) t_warm = cyc;
            if (por_n && !p_por) begin
                t_por = cyc;
                chk(t_por > t_warm, "R3", "por after warm", t_por, t_warm + 1);
                chk((t_por - anchor) * CLK_PS >= PWR_NS * 1000 &&
                    (t_por - anchor) * CLK_PS >= 500 * REF_PS,
                    "R2", "hold before por", t_por - anchor, E_HOLD);
            end
            if (strap_oe && !p_oe) t_oe_r = cyc;
            if (full_rst_n && !p_full) begin
                t_full = cyc;
                chk((t_full - t_por) * CLK_PS >= 24 * REF_PS,
                    "R4", "por to full", t_full - t_por, E_FULL);
                chk((t_full - t_oe_r) * CLK_PS >= 12 * REF_PS,
                    "R5", "strap setup", t_full - t_oe_r, E_STRAP);
            end
            if (!strap_oe && p_oe && full_rst_n) begin
                chk((cyc - t_full) * CLK_PS >= 12 * REF_PS,
                    "R5", "strap hold", cyc - t_full, E_STRAP);
            end
            p_warm = warm_rst_n; p_por = por_n; p_full = full_rst_n; p_oe = strap_oe;
        end
    end

    // Wait for an output to reach a level, at negedges.
    task automatic wait_out(input int sel, input bit lvl, input int cap_cyc, input string req);
        for (int i = 0; i < cap_cyc; i++) begin
            logic v;
            @(negedge clk);
            case (sel)
                0: v = full_rst_n;
                1: v = strap_oe;
                2: v = done;
                3: v = err;
                default: v = por_n;
            endcase
            if (v === lvl) return;
        end
        chk(1'b0, req, "wait timed out", sel, lvl);
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired R1 actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- scenarios ----------------
    initial begin
        rst_n = 0; pwr_good = 0; clk_stable = 0; start = 0; rst_stat = 0; cfg_i = CFG_A;
        repeat (3) @(negedge clk);
        pwr_good = 1;
        repeat (3) @(negedge clk);
        chk({warm_rst_n, por_n, full_rst_n, strap_oe, done, err} == 6'b0, "R1",
            "outputs in reset", {warm_rst_n, por_n, full_rst_n, strap_oe, done, err}, 0);
        pwr_good = 0;
        rst_n = 1;
        repeat (10) @(negedge clk);
        chk({warm_rst_n, por_n, full_rst_n, strap_oe} == 4'b0 && strap_o == '0, "R1",
            "outputs without power", {warm_rst_n, por_n, full_rst_n, strap_oe}, 0);

        // Power good, clock not yet stable: nothing released.
        pwr_good = 1;
        repeat (50) @(negedge clk);
        chk(warm_rst_n == 1'b0, "R2", "warm held without stable clock", warm_rst_n, 0);
        clk_stable = 1;

        // Full sequence; change cfg inside the window.
        wait_out(0, 1'b1, 10000, "R4");
        cfg_i = CFG_B;
        @(negedge clk);
        chk(strap_o == CFG_A, "R5", "strap frozen", strap_o, CFG_A);
        chk(strap_o[0] == CFG_A[0] && strap_o[13:1] == CFG_A[13:1], "R5",
            "byte order and boot mode fields", strap_o[13:0], CFG_A[13:0]);
        wait_out(1, 1'b0, 1000, "R6");
        chk(strap_o == '0, "R6", "strap released", strap_o, 0);
        repeat (20) @(negedge clk);
        rst_stat = 1;
        @(negedge clk);
        chk(done == 1'b1, "R7", "done after status", done, 1);
        repeat (10) @(negedge clk);
        chk(done && full_rst_n && por_n && warm_rst_n, "R7", "done held",
            {done, full_rst_n, por_n, warm_rst_n}, 4'hf);

        // Restart, then let status time out.
        rst_stat = 0;
        start = 1;
        @(negedge clk);
        start = 0;
        chk({warm_rst_n, por_n, full_rst_n, done} == 4'b0, "R9", "lines low after start",
            {warm_rst_n, por_n, full_rst_n, done}, 0);
        wait_out(3, 1'b1, 20000, "R8");
        @(negedge clk);
        chk(err == 1'b0 && warm_rst_n == 1'b0, "R8", "error one cycle, lines low",
            {err, warm_rst_n}, 0);

        // Retry: status already high before the straps are released.
        wait_out(0, 1'b1, 10000, "R4");
        chk(strap_o == CFG_B, "R5", "strap holds new word", strap_o, CFG_B);
        rst_stat = 1;
        wait_out(1, 1'b0, 1000, "R6");
        chk(done == 1'b0, "R7", "not done while straps driven", done, 0);
        @(negedge clk);
        chk(done == 1'b1, "R7", "early status completes", done, 1);

        // Power loss mid-sequence.
        rst_stat = 0;
        start = 1;
        @(negedge clk);
        start = 0;
        wait_out(4, 1'b1, 10000, "R3");
        repeat (20) @(negedge clk);
        pwr_good = 0;
        @(negedge clk);
        chk({warm_rst_n, por_n, full_rst_n, strap_oe} == 4'b0, "R10", "collapse on power loss",
            {warm_rst_n, por_n, full_rst_n, strap_oe}, 0);
        repeat (5) @(negedge clk);
        pwr_good = 1;
        wait_out(0, 1'b1, 10000, "R10");
        rst_stat = 1;
        wait_out(2, 1'b1, 1000, "R7");
        chk(done == 1'b1, "R10", "recovery after power returns", done, 1);
        repeat (5) @(negedge clk);

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule